// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is the 32-bit interrupt control and status register of a bus-master bridge. It records six kinds of event in sticky flags: the two bus-master abort types, read and write transfer completion, a local-side write to a chosen incoming mailbox, and a local-side read of a chosen outgoing mailbox. Software clears a flag by writing one to its bit. Writing zero leaves the flag alone. The bridge interrupt line stays high while any flag is pending.

The same word holds the per-source enables and the two mailbox-select fields. The top byte is a plain stored byte whose meaning belongs to other logic. Readback is combinational from the stored state, so a value written at a clock edge can be read in the next cycle. The transfer-complete indications are level signals from the counters. A completion flag is set only on the cycle in which its indication rises, so a count that stays at zero does not set the flag again after it has been cleared.

Top module: `irq_csr`

## Requirements
- R1: After reset, `rd_data` reads 0x00000000 and `irq` is low.
- R2: A one-cycle pulse on `tgt_abort_evt` sets bit 21, and a pulse on `mst_abort_evt` sets bit 20. Neither flag has an enable.
- R3: Bit 19 sets on the cycle `rd_cnt_zero` rises while enable bit 15 is one. Bit 18 sets on the cycle `wr_cnt_zero` rises while enable bit 14 is one. A rise with the enable at zero, or an indication held high, sets nothing.
- R4: Bit 17 sets when `mb_in_wr[k]` pulses, k equals bits 11:10 (00 picks strobe 0, 11 picks strobe 3) and enable bit 12 is one. A strobe for any other k is ignored.
- R5: Bit 16 sets when `mb_out_rd[k]` pulses, k equals bits 1:0 (same encoding as R4) and enable bit 4 is one. A strobe for any other k is ignored.
- R6: A write with a one in any of bits 21:16 clears that flag. A zero in those bits leaves the flag unchanged.
- R7: When a set event and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R8: Bit 23 and `irq` are both one exactly when any of bits 21:16 is set. Writes to bit 23 have no effect.
- R9: Bits 22, 13, 9:5 and 3:2 always read zero, whatever is written to them.
- R10: Bits 31:24, 15, 14, 12, 11:10, 4 and 1:0 are read/write. They read back the last value written and reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register readback |
| tgt_abort_evt | input | 1 | Target abort seen on a mastered cycle (pulse) |
| mst_abort_evt | input | 1 | No target response on a mastered cycle (pulse) |
| rd_cnt_zero | input | 1 | Read transfer count is zero (level) |
| wr_cnt_zero | input | 1 | Write transfer count is zero (level) |
| mb_in_wr | input | 4 | Local-side write strobes, one per incoming mailbox |
| mb_out_rd | input | 4 | Local-side read strobes, one per outgoing mailbox |
| irq | output | 1 | Level interrupt, high while any flag is pending |

## Verification
The bench aims at four corner cases:
- A write that clears a flag in the same cycle as a new event for that flag. A design that lets the clear win drops the event, and bit 20 reads zero.
- A write of zeros over pending flags. A design that stores the write data into the flags wipes them.
- Strobes from mailboxes that are not selected, completion rises while the enable is off, and a count-zero level held through a clear. A design that gets these wrong sets bits 17, 19 or 18 when it should not.
- A write of all ones. This shows whether reserved bits or the summary bit can be stored, and whether `irq` follows the flags and ignores the written value.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

    localparam int unsigned CSR_W     = 32;
    localparam int unsigned NUM_FLAGS = 6;
    localparam int unsigned NUM_MBOX  = 4;
    localparam int unsigned SEL_W     = $clog2(NUM_MBOX);

    // flag index inside the flag bank; bank bit i maps to csr bit FLAG_LSB + i
    typedef enum logic [2:0] {
        FLG_MB_OUT  = 3'd0,
        FLG_MB_IN   = 3'd1,
        FLG_WR_DONE = 3'd2,
        FLG_RD_DONE = 3'd3,
        FLG_MST_ABT = 3'd4,
        FLG_TGT_ABT = 3'd5
    } flag_idx_e;

    localparam int unsigned FLAG_LSB     = 16;
    localparam int unsigned SUMMARY_BIT  = 23;
    localparam int unsigned EN_RD_DONE   = 15;
    localparam int unsigned EN_WR_DONE   = 14;
    localparam int unsigned EN_MB_IN     = 12;
    localparam int unsigned SEL_IN_LSB   = 10;
    localparam int unsigned EN_MB_OUT    = 4;
    localparam int unsigned SEL_OUT_LSB  = 0;
    localparam int unsigned TOP_LSB      = 24;
    localparam int unsigned TOP_W        = 8;

    typedef struct packed {
        logic [TOP_W-1:0] top_byte;
        logic             en_rd_done;
        logic             en_wr_done;
        logic             en_mb_in;
        logic [SEL_W-1:0] sel_in;
        logic             en_mb_out;
        logic [SEL_W-1:0] sel_out;
    } ctrl_t;

endpackage

// File: rtl/irq_mbox_select.sv
module irq_mbox_select #(
    parameter int unsigned N_SRC = 4,
    localparam int unsigned SW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] strobes,
    input  logic [SW-1:0]    sel,
    input  logic             enable,
    output logic             hit
);

    logic [N_SRC-1:0] match;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign match[g] = strobes[g] && (sel == SW'(g));
    end

    assign hit = enable && (|match);

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned N_FLAG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] set_evt,
    input  logic [N_FLAG-1:0] clr_req,
    output logic [N_FLAG-1:0] flags
);

    for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (set_evt[g]) begin
                flags[g] <= 1'b1;
            end else if (clr_req[g]) begin
                flags[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_csr.sv
module irq_csr
    import irq_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CSR_W-1:0]    wr_data,
    output logic [CSR_W-1:0]    rd_data,
    input  logic                tgt_abort_evt,
    input  logic                mst_abort_evt,
    input  logic                rd_cnt_zero,
    input  logic                wr_cnt_zero,
    input  logic [NUM_MBOX-1:0] mb_in_wr,
    input  logic [NUM_MBOX-1:0] mb_out_rd,
    output logic                irq
);

    ctrl_t                ctrl_q;
    logic                 rdz_q;
    logic                 wrz_q;
    logic                 mb_in_hit;
    logic                 mb_out_hit;
    logic [NUM_FLAGS-1:0] set_evt;
    logic [NUM_FLAGS-1:0] clr_req;
    logic [NUM_FLAGS-1:0] flags;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rdz_q  <= 1'b0;
            wrz_q  <= 1'b0;
        end else begin
            rdz_q <= rd_cnt_zero;
            wrz_q <= wr_cnt_zero;
            if (wr_en) begin
                ctrl_q.top_byte   <= wr_data[TOP_LSB +: TOP_W];
                ctrl_q.en_rd_done <= wr_data[EN_RD_DONE];
                ctrl_q.en_wr_done <= wr_data[EN_WR_DONE];
                ctrl_q.en_mb_in   <= wr_data[EN_MB_IN];
                ctrl_q.sel_in     <= wr_data[SEL_IN_LSB +: SEL_W];
                ctrl_q.en_mb_out  <= wr_data[EN_MB_OUT];
                ctrl_q.sel_out    <= wr_data[SEL_OUT_LSB +: SEL_W];
            end
        end
    end

    irq_mbox_select #(.N_SRC(NUM_MBOX)) u_sel_in (
        .strobes (mb_in_wr),
        .sel     (ctrl_q.sel_in),
        .enable  (ctrl_q.en_mb_in),
        .hit     (mb_in_hit)
    );

    irq_mbox_select #(.N_SRC(NUM_MBOX)) u_sel_out (
        .strobes (mb_out_rd),
        .sel     (ctrl_q.sel_out),
        .enable  (ctrl_q.en_mb_out),
        .hit     (mb_out_hit)
    );

    always_comb begin
        set_evt              = '0;
        set_evt[FLG_TGT_ABT] = tgt_abort_evt;
        set_evt[FLG_MST_ABT] = mst_abort_evt;
        set_evt[FLG_RD_DONE] = rd_cnt_zero && !rdz_q && ctrl_q.en_rd_done;
        set_evt[FLG_WR_DONE] = wr_cnt_zero && !wrz_q && ctrl_q.en_wr_done;
        set_evt[FLG_MB_IN]   = mb_in_hit;
        set_evt[FLG_MB_OUT]  = mb_out_hit;
        clr_req = wr_en ? wr_data[FLAG_LSB +: NUM_FLAGS] : '0;
    end

    irq_flag_bank #(.N_FLAG(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .clr_req (clr_req),
        .flags   (flags)
    );

    always_comb begin
        rd_data                            = '0;
        rd_data[TOP_LSB +: TOP_W]          = ctrl_q.top_byte;
        rd_data[SUMMARY_BIT]               = |flags;
        rd_data[FLAG_LSB +: NUM_FLAGS]     = flags;
        rd_data[EN_RD_DONE]                = ctrl_q.en_rd_done;
        rd_data[EN_WR_DONE]                = ctrl_q.en_wr_done;
        rd_data[EN_MB_IN]                  = ctrl_q.en_mb_in;
        rd_data[SEL_IN_LSB +: SEL_W]       = ctrl_q.sel_in;
        rd_data[EN_MB_OUT]                 = ctrl_q.en_mb_out;
        rd_data[SEL_OUT_LSB +: SEL_W]      = ctrl_q.sel_out;
    end

    assign irq = |flags;

endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        tgt_abort_evt,
    input logic        mst_abort_evt,
    input logic        rd_cnt_zero,
    input logic        wr_cnt_zero,
    input logic [3:0]  mb_in_wr,
    input logic [3:0]  mb_out_rd,
    input logic        irq
);

    assert_tgt_abort_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_abort_evt |=> rd_data[21]);

    assert_rd_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15] && $rose(rd_cnt_zero)) |=> rd_data[19]);

    assert_mb_in_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[12] && mb_in_wr[rd_data[11:10]]) |=> rd_data[17]);

    assert_mb_out_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] && mb_out_rd[rd_data[1:0]]) |=> rd_data[16]);

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[21] && !tgt_abort_evt) |=> !rd_data[21]);

    assert_zero_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[20] && wr_en && !wr_data[20]) |=> rd_data[20]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[20] && mst_abort_evt) |=> rd_data[20]);

    assert_summary_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq == (rd_data[21:16] != 6'd0)) && (rd_data[23] == irq));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[22] == 1'b0) && (rd_data[13] == 1'b0) && (rd_data[9:5] == 5'd0)
        && (rd_data[3:2] == 2'd0));

    assert_ctrl_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[31:24] == $past(wr_data[31:24]))
                  && (rd_data[15:14] == $past(wr_data[15:14])));

endmodule

bind irq_csr irq_csr_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .tgt_abort_evt (tgt_abort_evt),
    .mst_abort_evt (mst_abort_evt),
    .rd_cnt_zero   (rd_cnt_zero),
    .wr_cnt_zero   (wr_cnt_zero),
    .mb_in_wr      (mb_in_wr),
    .mb_out_rd     (mb_out_rd),
    .irq           (irq)
);

// File: tb/irq_csr_tb.sv
module irq_csr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tgt_abort_evt = 1'b0;
    logic        mst_abort_evt = 1'b0;
    logic        rd_cnt_zero = 1'b0;
    logic        wr_cnt_zero = 1'b0;
    logic [3:0]  mb_in_wr = '0;
    logic [3:0]  mb_out_rd = '0;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_csr u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tgt_abort_evt(tgt_abort_evt), .mst_abort_evt(mst_abort_evt),
        .rd_cnt_zero(rd_cnt_zero), .wr_cnt_zero(wr_cnt_zero),
        .mb_in_wr(mb_in_wr), .mb_out_rd(mb_out_rd), .irq(irq)
    );

    // vector: {wr_en, wr_data[31:0], evt[11:0], expected rd_data[31:0]}
    // evt: [11] tgt abort, [10] mst abort, [9] rd zero, [8] wr zero, [7:4] mb_in, [3:0] mb_out
    localparam int NV = 15;
    localparam logic [76:0] VEC [NV] = '{
        {1'b1, 32'hA500D811, 12'h000, 32'hA500D811}, // R10 program controls
        {1'b0, 32'h0,        12'h800, 32'hA5A0D811}, // R2 target abort
        {1'b1, 32'hA520D811, 12'h000, 32'hA500D811}, // R6 clear bit 21
        {1'b0, 32'h0,        12'h010, 32'hA500D811}, // R4 mailbox 0 not selected
        {1'b0, 32'h0,        12'h040, 32'hA582D811}, // R4 selected mailbox 2
        {1'b0, 32'h0,        12'h002, 32'hA583D811}, // R5 selected outgoing 1
        {1'b1, 32'hA500D811, 12'h000, 32'hA583D811}, // R6 zeros keep flags
        {1'b1, 32'hA503D811, 12'h000, 32'hA500D811}, // R6 clear 17,16
        {1'b0, 32'h0,        12'h200, 32'hA588D811}, // R3 read count rise
        {1'b1, 32'hA508D811, 12'h200, 32'hA500D811}, // R3 held level, clear
        {1'b0, 32'h0,        12'h100, 32'hA584D811}, // R3 write count rise
        {1'b1, 32'hA514D811, 12'h500, 32'hA590D811}, // R7 collision on bit 20
        {1'b1, 32'h3C100000, 12'h000, 32'h3C000000}, // R10 disable all
        {1'b0, 32'h0,        12'h240, 32'h3C000000}, // R3 R4 enables off
        {1'b1, 32'h00000000, 12'h000, 32'h00000000}
    };

    task automatic check32(input bit ok, input string req, input logic [31:0] act,
                           input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [76:0] v);
        wr_en         = v[76];
        wr_data       = v[75:44];
        tgt_abort_evt = v[43];
        mst_abort_evt = v[42];
        rd_cnt_zero   = v[41];
        wr_cnt_zero   = v[40];
        mb_in_wr      = v[39:36];
        mb_out_rd     = v[35:32];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check32(rd_data == 32'h0, "R1 reset readback", rd_data, 32'h0);
        check32(irq == 1'b0, "R1 reset irq", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            check32(rd_data == VEC[i][31:0], $sformatf("vector %0d R2-R7 R10", i),
                    rd_data, VEC[i][31:0]);
            check32(irq == (VEC[i][21:16] != 6'd0), $sformatf("vector %0d R8 irq", i),
                    {31'd0, irq}, {31'd0, (VEC[i][21:16] != 6'd0)});
        end
        // R9 R8: write all ones; reserved and summary bits not stored
        apply({1'b1, 32'hFFFFFFFF, 12'h000, 32'h0});
        @(posedge clk); @(negedge clk);
        check32(rd_data == 32'hFF00DC13, "R9 reserved/R8 summary ignore write",
                rd_data, 32'hFF00DC13);
        // R7 collision on bit 21 with set
        apply({1'b1, 32'hFF20DC13, 12'h800, 32'h0});
        @(posedge clk); @(negedge clk);
        check32(rd_data == 32'hFFA0DC13, "R7 set wins on bit 21", rd_data, 32'hFFA0DC13);
        check32(irq == 1'b1, "R8 irq high", {31'd0, irq}, 32'h1);
        // R5 non-selected outgoing strobe ignored (sel_out = 3)
        apply({1'b1, 32'hFF20DC13, 12'h007, 32'h0});
        @(posedge clk); @(negedge clk);
        check32(rd_data == 32'hFF00DC13, "R5 other outgoing ignored", rd_data, 32'hFF00DC13);
        apply({1'b0, 32'h0, 12'h008, 32'h0});
        @(posedge clk); @(negedge clk);
        check32(rd_data == 32'hFF81DC13, "R5 outgoing 3 selected", rd_data, 32'hFF81DC13);
        // R1 reset during operation
        apply('0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check32(rd_data == 32'h0, "R1 reset clears all", rd_data, 32'h0);
        check32(irq == 1'b0, "R1 reset irq low", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule